// File: doc/BRIEF.md
# UART Interrupt Source Combiner

This block gathers the four interrupt causes of one serial channel into one level-sensitive request line. Each cause is held in a sticky source register. A mask register hides chosen causes. The masked pending view is the source bits with the masked ones removed, and the request line is high while any bit of that view is set. Software clears causes by writing ones, either through the pending clear port or through the source clear port.

The transmit cause has a second origin besides its event pulse: a threshold comparator. While the FIFO is enabled, the comparator sets the transmit bit on every cycle in which the transmit FIFO count is at or below the trigger level. The trigger level is a 3-bit field multiplied by a factor that depends on the channel. Channel 0 uses 32, channels 1 and 4 use 8, and channels 2 and 3 use 2. The channel is an elaboration parameter. The FIFOs and the serial engines sit outside this block.

Top module: `uirq_ctrl`

## Requirements
- R1: The source bits are assigned as follows: bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem. A one-cycle pulse on a cause input sets its bit at the next clock edge, and the bit stays set until it is cleared.
- R2: `pend_q` equals `src_q & ~mask_q` at all times, with no extra cycle of delay.
- R3: `irq` is high exactly when at least one bit of `pend_q` is set.
- R4: A pending-clear write clears every source bit whose data bit is one, so those bits also drop from `pend_q`. Bits written as zero keep their value.
- R5: A source-clear write clears every source bit whose data bit is one. Bits written as zero keep their value.
- R6: When a cause pulse (or a threshold hit) and a clear of the same bit arrive in the same cycle, the bit is set.
- R7: While `fifo_en` is high, each clock edge at which `tx_count <= tx_trig * scale` sets source bit 2. When the count is above the level, the bit is not set.
- R8: The scale is 32 when `CHAN_ID` is 0, 8 when it is 1 or 4, and 2 when it is 2 or 3.
- R9: While `fifo_en` is low, the threshold comparator has no effect on bit 2, whatever the count.
- R10: After reset, the source and mask registers are zero and `irq` is low.
- R11: A mask write replaces the mask with the written value at the next edge. A masked cause still latches into `src_q` and shows in `pend_q` once the mask is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx | input | 1 | Receive cause pulse |
| ev_err | input | 1 | Error cause pulse |
| ev_tx | input | 1 | Transmit cause pulse |
| ev_modem | input | 1 | Modem cause pulse |
| fifo_en | input | 1 | FIFO mode enable; gates the threshold comparator |
| tx_count | input | CNT_W | Current transmit FIFO fill count |
| tx_trig | input | 3 | Transmit trigger field, before scaling |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 4 | New mask value |
| pend_clr_wr | input | 1 | Pending clear strobe |
| pend_clr_data | input | 4 | Pending bits to clear (write one to clear) |
| src_clr_wr | input | 1 | Source clear strobe |
| src_clr_data | input | 4 | Source bits to clear (write one to clear) |
| src_q | output | 4 | Source register |
| mask_q | output | 4 | Mask register |
| pend_q | output | 4 | Masked pending bits |
| irq | output | 1 | Interrupt request, level |

## Verification
The case that is hardest to reach from the ports is the exact edge of the scaled trigger level, because the comparator drives the same bit that the clear ports try to reset. To reach it, the stimulus first drops `fifo_en`, clears bit 2 and confirms that it stays clear. It then raises `fifo_en` for one edge with the count at the level, and again with the count one above the level. Two instances with different channel parameters see the same count, so the same count must hit on one channel and miss on the other. A separate case issues a clear and a cause pulse in the same cycle to confirm that the set wins.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   localparam int SRC_N = 4;

   typedef enum logic [1:0] {
      SRC_RX    = 2'd0,
      SRC_ERR   = 2'd1,
      SRC_TX    = 2'd2,
      SRC_MODEM = 2'd3
   } src_idx_e;

   // per-channel multiplier applied to the transmit trigger field
   function automatic int chan_scale(input int chan);
      case (chan)
         0:       return 32;
         1, 4:    return 8;
         2, 3:    return 2;
         default: return 0;
      endcase
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/uirq_thresh.sv
module uirq_thresh #(
   parameter int CNT_W   = 8,
   parameter int CHAN_ID = 0
) (
   input  logic             fifo_en,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [2:0]       tx_trig,
   output logic             hit
);
   localparam int SCALE   = uirq_pkg::chan_scale(CHAN_ID);
   localparam int LVL_MAX = 7 * SCALE;
   localparam int LVL_W   = $clog2(LVL_MAX + 1);
   localparam int CMP_W   = (CNT_W > LVL_W) ? CNT_W : LVL_W;

   logic [CMP_W-1:0] level;

   generate
      if (uirq_pkg::is_pow2(SCALE)) begin : g_shift
         localparam int SH = $clog2(SCALE);
         assign level = CMP_W'(tx_trig) << SH;
      end else begin : g_mult
         assign level = CMP_W'(tx_trig) * CMP_W'(SCALE);
      end
   endgenerate

   assign hit = fifo_en && (CMP_W'(tx_count) <= level);

endmodule

// File: rtl/uirq_src_reg.sv
module uirq_src_reg #(
   parameter int N = uirq_pkg::SRC_N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_v,
   input  logic [N-1:0] clr_v,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q[i] <= 1'b0;
            else if (set_v[i])   q[i] <= 1'b1;
            else if (clr_v[i])   q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg #(
   parameter int N = uirq_pkg::SRC_N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wdata;
   end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl #(
   parameter int CNT_W   = 8,
   parameter int CHAN_ID = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_rx,
   input  logic             ev_err,
   input  logic             ev_tx,
   input  logic             ev_modem,
   input  logic             fifo_en,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [2:0]       tx_trig,
   input  logic             mask_wr,
   input  logic [3:0]       mask_wdata,
   input  logic             pend_clr_wr,
   input  logic [3:0]       pend_clr_data,
   input  logic             src_clr_wr,
   input  logic [3:0]       src_clr_data,
   output logic [3:0]       src_q,
   output logic [3:0]       mask_q,
   output logic [3:0]       pend_q,
   output logic             irq
);
   import uirq_pkg::*;

   generate
      if (CHAN_ID < 0 || CHAN_ID > 4) begin : g_bad_chan
         $error("uirq_ctrl: CHAN_ID must lie in 0..4");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("uirq_ctrl: CNT_W must be positive");
      end
   endgenerate

   logic             thr_hit;
   logic [SRC_N-1:0] set_v;
   logic [SRC_N-1:0] clr_v;

   uirq_thresh #(.CNT_W(CNT_W), .CHAN_ID(CHAN_ID)) u_thresh (
      .fifo_en  (fifo_en),
      .tx_count (tx_count),
      .tx_trig  (tx_trig),
      .hit      (thr_hit)
   );

   always_comb begin
      set_v            = '0;
      set_v[SRC_RX]    = ev_rx;
      set_v[SRC_ERR]   = ev_err;
      set_v[SRC_TX]    = ev_tx | thr_hit;
      set_v[SRC_MODEM] = ev_modem;
      clr_v = (pend_clr_wr ? pend_clr_data : '0) | (src_clr_wr ? src_clr_data : '0);
   end

   uirq_src_reg #(.N(SRC_N)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (set_v),
      .clr_v (clr_v),
      .q     (src_q)
   );

   uirq_mask_reg #(.N(SRC_N)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (mask_wr),
      .wdata (mask_wdata),
      .q     (mask_q)
   );

   assign pend_q = src_q & ~mask_q;
   assign irq    = |pend_q;

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_rx,
   input logic             ev_err,
   input logic             ev_tx,
   input logic             ev_modem,
   input logic             fifo_en,
   input logic [CNT_W-1:0] tx_count,
   input logic             mask_wr,
   input logic [3:0]       mask_wdata,
   input logic             pend_clr_wr,
   input logic [3:0]       pend_clr_data,
   input logic             src_clr_wr,
   input logic [3:0]       src_clr_data,
   input logic [3:0]       src_q,
   input logic [3:0]       mask_q,
   input logic [3:0]       pend_q,
   input logic             irq
);
   p_rx_set_r1: assert property (@(posedge clk) disable iff (!rst_n) ev_rx |=> src_q[0]);
   p_err_set_r1: assert property (@(posedge clk) disable iff (!rst_n) ev_err |=> src_q[1]);
   p_tx_set_r1: assert property (@(posedge clk) disable iff (!rst_n) ev_tx |=> src_q[2]);
   p_mdm_set_r1: assert property (@(posedge clk) disable iff (!rst_n) ev_modem |=> src_q[3]);
   p_masked_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n) (pend_q & mask_q) == 4'h0);
   p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n) (mask_q == 4'hF) |-> !irq);
   p_rx_raises_r3: assert property (@(posedge clk) disable iff (!rst_n) (src_q[0] && !mask_q[0]) |-> irq);
   p_pend_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr_wr && pend_clr_data[0] && !ev_rx) |=> !src_q[0]);
   p_src_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_clr_wr && src_clr_data[3] && !ev_modem) |=> !src_q[3]);
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_err && src_clr_wr && src_clr_data[1]) |=> src_q[1]);
   p_empty_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && tx_count == '0) |=> src_q[2]);
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && !ev_rx && !ev_err && !ev_tx && !ev_modem && !pend_clr_wr && !src_clr_wr)
      |=> $stable(src_q));
   p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_q == $past(mask_wdata)));
endmodule

bind uirq_ctrl uirq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
   .ev_modem(ev_modem), .fifo_en(fifo_en), .tx_count(tx_count),
   .mask_wr(mask_wr), .mask_wdata(mask_wdata), .pend_clr_wr(pend_clr_wr),
   .pend_clr_data(pend_clr_data), .src_clr_wr(src_clr_wr),
   .src_clr_data(src_clr_data), .src_q(src_q), .mask_q(mask_q),
   .pend_q(pend_q), .irq(irq)
);

// File: tb/sim_uirq_ctrl.sv
`timescale 1ns/1ps
module sim_uirq_ctrl;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_rx = 0, ev_err = 0, ev_tx = 0, ev_modem = 0, fifo_en = 0;
   logic [CNT_W-1:0] tx_count = '0;
   logic [2:0] tx_trig = '0;
   logic mask_wr = 0, pend_clr_wr = 0, src_clr_wr = 0;
   logic [3:0] mask_wdata = '0, pend_clr_data = '0, src_clr_data = '0;
   logic [3:0] src0, mask0, pend0, src1, mask1, pend1;
   logic irq0, irq1;
   int total = 0, bad = 0, cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   uirq_ctrl #(.CNT_W(CNT_W), .CHAN_ID(0)) u0 (
      .clk, .rst_n, .ev_rx, .ev_err, .ev_tx, .ev_modem, .fifo_en, .tx_count, .tx_trig,
      .mask_wr, .mask_wdata, .pend_clr_wr, .pend_clr_data, .src_clr_wr, .src_clr_data,
      .src_q(src0), .mask_q(mask0), .pend_q(pend0), .irq(irq0));

   uirq_ctrl #(.CNT_W(CNT_W), .CHAN_ID(3)) u1 (
      .clk, .rst_n, .ev_rx, .ev_err, .ev_tx, .ev_modem, .fifo_en, .tx_count, .tx_trig,
      .mask_wr, .mask_wdata, .pend_clr_wr, .pend_clr_data, .src_clr_wr, .src_clr_data,
      .src_q(src1), .mask_q(mask1), .pend_q(pend1), .irq(irq1));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      {ev_rx, ev_err, ev_tx, ev_modem} = '0;
      {mask_wr, pend_clr_wr, src_clr_wr} = '0;
   endtask

   task automatic clr_all();
      fifo_en = 0; src_clr_wr = 1; src_clr_data = 4'hF; mask_wr = 1; mask_wdata = 4'h0;
      tick(); idle();
   endtask

   task automatic t_reset();
      chk("R10 src", 8'(src0), 8'h0);
      chk("R10 mask", 8'(mask0), 8'h0);
      chk("R10 irq", 8'(irq0), 8'h0);
   endtask

   task automatic t_events();
      ev_rx = 1; tick(); idle();
      chk("R1 rx bit0", 8'(src0), 8'h1);
      chk("R3 irq on rx", 8'(irq0), 8'h1);
      tick();
      chk("R1 sticky", 8'(src0), 8'h1);
      ev_err = 1; ev_modem = 1; tick(); idle();
      chk("R1 err+modem", 8'(src0), 8'hB);
      ev_tx = 1; tick(); idle();
      chk("R1 tx bit2", 8'(src0), 8'hF);
      clr_all();
   endtask

   task automatic t_mask();
      mask_wr = 1; mask_wdata = 4'h5; tick(); idle();
      chk("R11 mask load", 8'(mask0), 8'h5);
      ev_rx = 1; tick(); idle();
      chk("R11 masked latches", 8'(src0), 8'h1);
      chk("R2 pend masked", 8'(pend0), 8'h0);
      chk("R3 irq low masked", 8'(irq0), 8'h0);
      ev_err = 1; tick(); idle();
      chk("R2 pend err", 8'(pend0), 8'h2);
      mask_wr = 1; mask_wdata = 4'h2; tick(); idle();
      chk("R11 unmask shows", 8'(pend0), 8'h1);
      chk("R3 irq", 8'(irq0), 8'h1);
      clr_all();
   endtask

   task automatic t_clears();
      ev_rx = 1; ev_err = 1; ev_modem = 1; tick(); idle();
      pend_clr_wr = 1; pend_clr_data = 4'h3; tick(); idle();
      chk("R4 pend clear", 8'(src0), 8'h8);
      chk("R4 pend view", 8'(pend0), 8'h8);
      src_clr_wr = 1; src_clr_data = 4'h8; tick(); idle();
      chk("R5 src clear", 8'(src0), 8'h0);
      chk("R3 irq low", 8'(irq0), 8'h0);
      ev_rx = 1; tick(); idle();
      src_clr_wr = 1; src_clr_data = 4'h0; tick(); idle();
      chk("R5 zero keeps", 8'(src0), 8'h1);
      clr_all();
   endtask

   task automatic t_priority();
      ev_err = 1; src_clr_wr = 1; src_clr_data = 4'h2; tick(); idle();
      chk("R6 set beats src clr", 8'(src0), 8'h2);
      ev_modem = 1; pend_clr_wr = 1; pend_clr_data = 4'hA; tick(); idle();
      chk("R6 set beats pend clr", 8'(src0), 8'h8);
      clr_all();
   endtask

   task automatic thr_step(input logic [2:0] trig, input logic [7:0] cnt,
                           input bit e0, input bit e1, input string tag);
      fifo_en = 0; src_clr_wr = 1; src_clr_data = 4'h4; tick(); idle();
      tx_trig = trig; tx_count = cnt; fifo_en = 1; tick(); fifo_en = 0;
      chk({tag, " ch0"}, 8'(src0[2]), 8'(e0));
      chk({tag, " ch3"}, 8'(src1[2]), 8'(e1));
   endtask

   task automatic t_thresh();
      thr_step(3'd1, 8'd32, 1, 0, "R7 R8 trig1 cnt32");
      thr_step(3'd1, 8'd33, 0, 0, "R7 R8 trig1 cnt33");
      thr_step(3'd1, 8'd2, 1, 1, "R8 trig1 cnt2");
      thr_step(3'd1, 8'd3, 1, 0, "R8 trig1 cnt3");
      thr_step(3'd7, 8'd224, 1, 0, "R7 trig7 cnt224");
      thr_step(3'd7, 8'd225, 0, 0, "R7 trig7 cnt225");
      thr_step(3'd0, 8'd0, 1, 1, "R7 trig0 cnt0");
      thr_step(3'd0, 8'd1, 0, 0, "R7 trig0 cnt1");
      clr_all();
   endtask

   task automatic t_fifo_off();
      tx_count = 0; tx_trig = 3'd7; fifo_en = 0; tick(); tick();
      chk("R9 no hit ch0", 8'(src0), 8'h0);
      chk("R9 no hit ch3", 8'(src1), 8'h0);
   endtask

   initial begin
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 5000 && !done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog act=%0d exp=<5000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      #1; tick(); tick();
      t_reset();
      rst_n = 1; tick();
      t_reset();
      t_events();
      t_mask();
      t_clears();
      t_priority();
      t_thresh();
      t_fifo_off();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule